// File: doc/BRIEF.md
# Programmable Video Timing Composer

This block produces the frame timing for progressive video. It counts pixels and lines from programmed geometry values and drives horizontal sync, vertical sync, data-enable and a frame-start pulse. The geometry is given as an active width and a total blanking width per axis. Each sync pulse is placed by a delay counted from the end of the active region, plus a pulse width. The delay is the front porch, and the back porch is whatever blanking is left over.

While data-enable is low, the block replaces the three pixel components with a programmed stuffing byte. While data-enable is high, the incoming pixels pass through unchanged. In HDMI mode it also classifies each blanking pixel as a line control period or a frame control period. It flags when the current blanking run has reached the minimum length for that kind of period, and it presents a fixed preamble code for each of the three TMDS channels. In DVI mode these control outputs stay at zero.

Every programmed value, including polarities, the mode and the stuffing byte, is captured into shadow registers. The capture happens only at the start of a frame, so software can rewrite the inputs at any time without tearing the current frame.

Top module: `vid_timing_gen`

## Requirements
- R1: A line lasts h_active_i + h_blank_i pixel clocks, and a frame lasts v_active_i + v_blank_i lines.
- R2: de_o is high exactly on pixels 0 to h_active_i-1 of lines 0 to v_active_i-1, and low everywhere else.
- R3: The hsync pulse is active on every line for h_sync_wid_i pixels. It begins h_sync_dly_i pixels after the last active pixel, so it covers pixel indices h_active_i+h_sync_dly_i up to h_active_i+h_sync_dly_i+h_sync_wid_i-1.
- R4: The vsync pulse covers whole lines, with indices v_active_i+v_sync_dly_i up to v_active_i+v_sync_dly_i+v_sync_wid_i-1. It changes level only at pixel 0 of a line.
- R5: A polarity input of 1 makes its sync output active high. A polarity input of 0 makes it active low.
- R6: pix_o equals pix_i while de_o is high. While de_o is low, all three bytes of pix_o equal stuff_i.
- R7: frame_start_o is high for exactly one pixel per frame: pixel 0 of line 0, which is also the first active pixel.
- R8: All programmed inputs take effect only at the next frame start. A change made mid-frame leaves the rest of the current frame unchanged.
- R9: In HDMI mode (hdmi_mode_i=1), ctrl_kind_o is 0 while de_o is high. It is 1 on blanking pixels of active lines and 2 on every pixel of vertical-blanking lines.
- R10: In HDMI mode, ctrl_min_o is high on a blanking pixel once the run of consecutive de-low pixels, counting the current one, has reached 12 for kind 1 or 32 for kind 2.
- R11: In HDMI mode, pream_o during blanking carries channel 0 in bits 7:0 as 0x0b, channel 1 in bits 15:8 as 0x16, and channel 2 in bits 23:16 as 0x21. It is 0 while de_o is high.
- R12: In DVI mode (hdmi_mode_i=0), ctrl_kind_o, ctrl_min_o and pream_o stay at 0.
- R13: While rst_ni is low, de_o, frame_start_o, ctrl_min_o, ctrl_kind_o, pream_o and pix_o are all 0. The first frame starts on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| h_active_i | input | 16 | Active pixels per line |
| h_blank_i | input | 16 | Horizontal blanking pixels |
| h_sync_dly_i | input | 16 | Pixels from end of active to hsync start |
| h_sync_wid_i | input | 16 | Hsync width in pixels |
| v_active_i | input | 16 | Active lines per frame |
| v_blank_i | input | 8 | Vertical blanking lines |
| v_sync_dly_i | input | 8 | Lines from end of active to vsync start |
| v_sync_wid_i | input | 8 | Vsync width in lines |
| hs_pol_i | input | 1 | 1: hsync active high |
| vs_pol_i | input | 1 | 1: vsync active high |
| hdmi_mode_i | input | 1 | 1: HDMI, 0: DVI |
| stuff_i | input | 8 | Component value while de_o is low |
| pix_i | input | 24 | Incoming pixel, three components |
| pix_o | output | 24 | Outgoing pixel |
| de_o | output | 1 | Data enable, active high |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| frame_start_o | output | 1 | First active pixel of the frame |
| ctrl_kind_o | output | 2 | 0 none, 1 line control, 2 frame control |
| ctrl_min_o | output | 1 | Minimum control-period length reached |
| pream_o | output | 24 | Per-channel preamble codes |

## Verification
The hardest situation to reach is a frame control period whose run is still shorter than 32 pixels as the frame enters vertical blanking. In that case the flag set during the previous line's horizontal blanking must drop, and then rise again partway through the first blanking line. The stimulus reaches it with a configuration whose horizontal blanking is shorter than 32 pixels. A second configuration has a horizontal blanking of 40 pixels, so there the flag stays high across the boundary. Each table vector is written mid-frame, which makes the frame running at that moment the one that proves shadowing. A model in the bench follows every pixel through the transition.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  localparam int unsigned LINE_CTRL_MIN  = 12;
  localparam int unsigned FRAME_CTRL_MIN = 32;
  localparam int unsigned N_CHAN         = 3;
  localparam int unsigned CODE_W         = 8;

  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_LINE  = 2'd1,
    CK_FRAME = 2'd2
  } ctrl_kind_e;

  function automatic logic [CODE_W-1:0] pream_code(input int unsigned ch);
    case (ch)
      0:       return 8'h0b;
      1:       return 8'h16;
      default: return 8'h21;
    endcase
  endfunction
endpackage

// File: rtl/vtc_shadow.sv
module vtc_shadow #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  a_r8_hold_between_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/vtc_counters.sv
module vtc_counters #(
  parameter int HCW = 17,
  parameter int VCW = 17
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [HCW-1:0] h_total_i,
  input  logic [VCW-1:0] v_total_i,
  output logic [HCW-1:0] h_o,
  output logic [VCW-1:0] v_o,
  output logic           wrap_o
);
  logic h_last, v_last;

  assign h_last = (h_o == h_total_i - 1'b1);
  assign v_last = (v_o == v_total_i - 1'b1);
  assign wrap_o = run_i && h_last && v_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o <= '0;
      v_o <= '0;
    end else if (run_i) begin
      if (h_last) begin
        h_o <= '0;
        v_o <= v_last ? '0 : v_o + 1'b1;
      end else begin
        h_o <= h_o + 1'b1;
      end
    end
  end

  a_r1_h_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> h_o < h_total_i);
  a_r1_v_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> v_o < v_total_i);
endmodule

// File: rtl/vtc_ctrl.sv
module vtc_ctrl
  import vtc_pkg::*;
#(
  parameter int RUN_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     active_i,
  input  logic                     de_i,
  input  logic                     frame_blank_i,
  input  logic                     hdmi_i,
  output logic [1:0]               kind_o,
  output logic                     min_o,
  output logic [N_CHAN*CODE_W-1:0] pream_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W:0]   LIM_LINE  = (RUN_W+1)'(LINE_CTRL_MIN);
  localparam logic [RUN_W:0]   LIM_FRAME = (RUN_W+1)'(FRAME_CTRL_MIN);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W:0]   run_now, limit;
  logic             ctl_on;
  ctrl_kind_e       kind;

  // consecutive de-low pixels before the current one, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (!active_i || de_i)  run_q <= '0;
    else if (run_q != RUN_MAX)   run_q <= run_q + 1'b1;
  end

  assign ctl_on  = active_i && !de_i && hdmi_i;
  assign run_now = {1'b0, run_q} + 1'b1;
  assign limit   = frame_blank_i ? LIM_FRAME : LIM_LINE;
  assign min_o   = ctl_on && (run_now >= limit);

  always_comb begin
    kind = CK_NONE;
    if (ctl_on) kind = frame_blank_i ? CK_FRAME : CK_LINE;
  end
  assign kind_o = kind;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    assign pream_o[c*CODE_W +: CODE_W] = ctl_on ? pream_code(c) : '0;
  end

  a_r9_none_in_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_i |-> kind_o == CK_NONE);
  a_r11_pream_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pream_o) |-> !de_i && kind_o != CK_NONE);
  a_r10_min_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_o |-> run_q >= RUN_W'(LINE_CTRL_MIN - 1));
  a_r12_dvi_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdmi_i |-> !min_o && pream_o == '0);
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtc_pkg::*;
#(
  parameter int HW    = 16,
  parameter int VAW   = 16,
  parameter int VBW   = 8,
  parameter int PW    = 8,
  parameter int RUN_W = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [HW-1:0]            h_active_i,
  input  logic [HW-1:0]            h_blank_i,
  input  logic [HW-1:0]            h_sync_dly_i,
  input  logic [HW-1:0]            h_sync_wid_i,
  input  logic [VAW-1:0]           v_active_i,
  input  logic [VBW-1:0]           v_blank_i,
  input  logic [VBW-1:0]           v_sync_dly_i,
  input  logic [VBW-1:0]           v_sync_wid_i,
  input  logic                     hs_pol_i,
  input  logic                     vs_pol_i,
  input  logic                     hdmi_mode_i,
  input  logic [PW-1:0]            stuff_i,
  input  logic [N_CHAN*PW-1:0]     pix_i,
  output logic [N_CHAN*PW-1:0]     pix_o,
  output logic                     de_o,
  output logic                     hsync_o,
  output logic                     vsync_o,
  output logic                     frame_start_o,
  output logic [1:0]               ctrl_kind_o,
  output logic                     ctrl_min_o,
  output logic [N_CHAN*CODE_W-1:0] pream_o
);
  localparam int HCW   = HW + 1;
  localparam int VCW   = ((VAW > VBW) ? VAW : VBW) + 1;
  localparam int HSW   = HW + 2;
  localparam int VSW   = VCW + 1;
  localparam int CFG_W = 4*HW + VAW + 3*VBW + 3 + PW;

  logic             primed_q, load;
  logic [CFG_W-1:0] cfg_d, cfg_q;

  logic [HW-1:0]  s_hact, s_hblank, s_hdly, s_hwid;
  logic [VAW-1:0] s_vact;
  logic [VBW-1:0] s_vblank, s_vdly, s_vwid;
  logic           s_hpol, s_vpol, s_hdmi;
  logic [PW-1:0]  s_stuff;

  logic [HCW-1:0] h_cnt, h_total;
  logic [VCW-1:0] v_cnt, v_total;
  logic           wrap;
  logic [HSW-1:0] hs_beg, hs_end;
  logic [VSW-1:0] vs_beg, vs_end;
  logic           line_act, de, hs_act, vs_act;

  assign cfg_d = {stuff_i, hdmi_mode_i, vs_pol_i, hs_pol_i, v_sync_wid_i, v_sync_dly_i,
                  v_blank_i, v_active_i, h_sync_wid_i, h_sync_dly_i, h_blank_i, h_active_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  assign load = !primed_q || wrap;

  vtc_shadow #(.W(CFG_W)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    (cfg_d),
    .q_o    (cfg_q)
  );

  assign {s_stuff, s_hdmi, s_vpol, s_hpol, s_vwid, s_vdly,
          s_vblank, s_vact, s_hwid, s_hdly, s_hblank, s_hact} = cfg_q;

  assign h_total = HCW'(s_hact) + HCW'(s_hblank);
  assign v_total = VCW'(s_vact) + VCW'(s_vblank);

  vtc_counters #(.HCW(HCW), .VCW(VCW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (primed_q),
    .h_total_i (h_total),
    .v_total_i (v_total),
    .h_o       (h_cnt),
    .v_o       (v_cnt),
    .wrap_o    (wrap)
  );

  // sync windows measured from end of active region
  assign hs_beg = HSW'(s_hact) + HSW'(s_hdly);
  assign hs_end = hs_beg + HSW'(s_hwid);
  assign vs_beg = VSW'(s_vact) + VSW'(s_vdly);
  assign vs_end = vs_beg + VSW'(s_vwid);

  assign line_act = v_cnt < VCW'(s_vact);
  assign de       = primed_q && line_act && (h_cnt < HCW'(s_hact));
  assign hs_act   = primed_q && (HSW'(h_cnt) >= hs_beg) && (HSW'(h_cnt) < hs_end);
  assign vs_act   = primed_q && (VSW'(v_cnt) >= vs_beg) && (VSW'(v_cnt) < vs_end);

  assign de_o          = de;
  assign hsync_o       = s_hpol ? hs_act : !hs_act;
  assign vsync_o       = s_vpol ? vs_act : !vs_act;
  assign frame_start_o = de && (h_cnt == '0) && (v_cnt == '0);

  for (genvar c = 0; c < N_CHAN; c++) begin : g_pix
    assign pix_o[c*PW +: PW] = de ? pix_i[c*PW +: PW] : s_stuff;
  end

  vtc_ctrl #(.RUN_W(RUN_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .active_i      (primed_q),
    .de_i          (de),
    .frame_blank_i (!line_act),
    .hdmi_i        (s_hdmi),
    .kind_o        (ctrl_kind_o),
    .min_o         (ctrl_min_o),
    .pream_o       (pream_o)
  );

  a_r7_start_is_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> de_o);
  a_r7_start_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(primed_q) && frame_start_o |-> $past(wrap));
  a_r4_vsync_at_line_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && h_cnt != '0 |-> $stable(vsync_o));
endmodule

// File: tb/vid_timing_gen_tb_top.sv
`timescale 1ns/1ps
module vid_timing_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] pix_i = '0;
  logic [23:0] pix_o, pream_o;
  logic        de_o, hsync_o, vsync_o, frame_start_o, ctrl_min_o;
  logic [1:0]  ctrl_kind_o;

  // fields: hact hblank hdly hwid vact vblank vdly vwid hpol vpol hdmi stuff | exp_de exp_hs
  localparam int unsigned VEC [4][14] = '{
    '{ 8, 20,  3,  4, 3, 4, 1, 2, 1, 1, 1,   0, 24,  28},
    '{16, 14,  2,  6, 4, 3, 0, 1, 0, 0, 1,  90, 64,  42},
    '{ 5, 13,  0, 13, 2, 6, 2, 3, 1, 0, 0, 255, 10, 104},
    '{12, 40, 10,  8, 2, 2, 1, 1, 0, 1, 1,  17, 24,  32}
  };

  int unsigned cur [12];
  int unsigned s   [12];
  int          m_h, m_v, m_run;
  bit          m_primed;
  int          pend;
  int          n_chk, n_fail;
  bit          done;

  always #4 clk_i = ~clk_i;

  vid_timing_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .h_active_i(16'(cur[0])), .h_blank_i(16'(cur[1])),
    .h_sync_dly_i(16'(cur[2])), .h_sync_wid_i(16'(cur[3])),
    .v_active_i(16'(cur[4])), .v_blank_i(8'(cur[5])),
    .v_sync_dly_i(8'(cur[6])), .v_sync_wid_i(8'(cur[7])),
    .hs_pol_i(cur[8][0]), .vs_pol_i(cur[9][0]), .hdmi_mode_i(cur[10][0]),
    .stuff_i(8'(cur[11])), .pix_i(pix_i), .pix_o(pix_o), .de_o(de_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .frame_start_o(frame_start_o),
    .ctrl_kind_o(ctrl_kind_o), .ctrl_min_o(ctrl_min_o), .pream_o(pream_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at h=%0d v=%0d: actual=0x%0h expected=0x%0h", req, m_h, m_v, act, exp);
    end
  endtask

  task automatic compare();
    bit e_line, e_de, e_hs, e_vs, e_fs, e_min, blank;
    int e_kind;
    logic [23:0] e_pre, e_pix;
    e_line = m_v < int'(s[4]);
    e_de   = m_primed && e_line && m_h < int'(s[0]);
    e_hs   = m_primed && m_h >= int'(s[0]+s[2]) && m_h < int'(s[0]+s[2]+s[3]);
    e_vs   = m_primed && m_v >= int'(s[4]+s[6]) && m_v < int'(s[4]+s[6]+s[7]);
    if (s[8] == 0) e_hs = !e_hs;
    if (s[9] == 0) e_vs = !e_vs;
    e_fs   = m_primed && m_h == 0 && m_v == 0;
    blank  = m_primed && s[10] != 0 && !e_de;
    e_kind = blank ? (e_line ? 1 : 2) : 0;
    e_min  = blank && (m_run + 1 >= (e_line ? 12 : 32));
    e_pre  = blank ? 24'h21160b : 24'h0;
    e_pix  = e_de ? pix_i : {3{8'(s[11])}};
    chk(de_o == e_de, "R2", de_o, e_de);
    chk(hsync_o == e_hs, "R3 R5", hsync_o, e_hs);
    chk(vsync_o == e_vs, "R4 R5", vsync_o, e_vs);
    chk(frame_start_o == e_fs, "R7", frame_start_o, e_fs);
    chk(pix_o == e_pix, "R6", pix_o, e_pix);
    if (s[10] != 0) begin
      chk(ctrl_kind_o == 2'(e_kind), "R9", ctrl_kind_o, e_kind);
      chk(ctrl_min_o == e_min, "R10", ctrl_min_o, e_min);
      chk(pream_o == e_pre, "R11", pream_o, e_pre);
    end else begin
      chk(ctrl_kind_o == 0 && !ctrl_min_o && pream_o == 0, "R12",
          {ctrl_kind_o, ctrl_min_o, pream_o}, 0);
    end
  endtask

  task automatic step();
    bit pre_de;
    @(posedge clk_i);
    if (!m_primed) begin
      m_primed = 1; m_h = 0; m_v = 0; m_run = 0;
      for (int k = 0; k < 12; k++) s[k] = cur[k];
    end else begin
      pre_de = m_v < int'(s[4]) && m_h < int'(s[0]);
      m_run  = pre_de ? 0 : ((m_run < 63) ? m_run + 1 : 63);
      if (m_h == int'(s[0] + s[1]) - 1) begin
        m_h = 0;
        if (m_v == int'(s[4] + s[5]) - 1) begin
          m_v = 0;
          for (int k = 0; k < 12; k++) s[k] = cur[k];
        end else m_v++;
      end else m_h++;
    end
  endtask

  task automatic cycle(inout int de_cnt, inout int hs_cnt);
    @(negedge clk_i);
    if (pend >= 0) begin
      for (int k = 0; k < 12; k++) cur[k] = VEC[pend][k];
      pend = -1;
    end
    pix_i = {8'(m_h * 7 + 3), 8'(m_v * 13 + m_h), 8'(m_h ^ 8'h5c)};
    #1;
    compare();
    if (de_o) de_cnt++;
    if (hsync_o == s[8][0]) hs_cnt++;
    step();
  endtask

  task automatic run_frame(output int de_cnt, output int hs_cnt);
    de_cnt = 0; hs_cnt = 0;
    do cycle(de_cnt, hs_cnt); while (!(m_h == 0 && m_v == 0));
  endtask

  initial begin
    int dc, hc;
    n_chk = 0; n_fail = 0; pend = -1; done = 0; m_primed = 0; m_run = 0;
    m_h = 0; m_v = 0;
    for (int k = 0; k < 12; k++) begin cur[k] = VEC[0][k]; s[k] = 0; end
    repeat (3) @(negedge clk_i);
    #1;
    // R13: outputs quiet during reset
    chk(de_o == 0 && frame_start_o == 0 && ctrl_min_o == 0, "R13", {de_o, frame_start_o, ctrl_min_o}, 0);
    chk(ctrl_kind_o == 0 && pream_o == 0 && pix_o == 0, "R13", {ctrl_kind_o, pream_o, pix_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    for (int i = 0; i < 4; i++) begin
      pend = i;
      run_frame(dc, hc);
      // R8: frame running while the new vector was written keeps the old geometry
      chk(dc == int'(VEC[(i == 0) ? 0 : i-1][12]), "R8", dc, VEC[(i == 0) ? 0 : i-1][12]);
      run_frame(dc, hc);
      chk(dc == int'(VEC[i][12]), "R1 R2", dc, VEC[i][12]);
      chk(hc == int'(VEC[i][13]), "R3", hc, VEC[i][13]);
    end
    // R13: asynchronous reset mid-frame
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(de_o == 0 && frame_start_o == 0 && ctrl_kind_o == 0 && pream_o == 0, "R13",
        {de_o, frame_start_o, ctrl_kind_o, pream_o}, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule